// File: doc/BRIEF.md
# Holdover Frequency Word Store

This block keeps a delayed copy of a clock loop's frequency control word. When the loop's reference is lost, the output oscillator can then be frozen on a value that the disturbance has not yet reached. A prescaler turns the system clock into a sample slot every 26 ms. In each slot in which the loop is locked and not in holdover, the current word is written into one of two snapshot registers. The two registers are used in turn.

The block always presents the older of the two snapshots. Any value applied in holdover is therefore between one and two sample intervals old, and never the newest sample. The oscillator that consumes the word has to reproduce it to within 0.15 ppm. That figure does not include master clock drift. While holdover is requested, or while the loop is unlocked, no snapshot is written and the presented word does not move. The loop filter, phase detector and drift compensation sit outside this block.

Top module: `holdover_word_store`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `held_word_o` equals the parameter `NOMINAL_WORD` and `held_valid_o` is 0.
- R2: The prescaler advances only in cycles where `tick_en_i` is 1. Every `PERIOD` = (`CLK_HZ`/1_000_000)·`INTERVAL_US` advancing cycles, it produces one sample slot. With `tick_en_i` at 0, the presented word is unchanged in the next cycle.
- R3: After k ≥ 2 captures, `held_word_o` equals the word captured by capture k−1, which is the second most recent. After exactly one capture it still equals `NOMINAL_WORD`.
- R4: A sample slot that occurs while `locked_i` is 0 captures nothing. Both outputs are unchanged in the next cycle.
- R5: A sample slot that occurs while `holdover_req_i` is 1 captures nothing. While `holdover_req_i` is 1, `held_word_o` stays constant.
- R6: `held_valid_o` is 0 until the second capture after reset has completed. It becomes 1 in the cycle after that capture and stays 1 until the next reset.
- R7: `held_word_o` changes only in the cycle that directly follows a capture.
- R8: Skipping a slot does not shift the schedule. The prescaler keeps counting through holdover and unlock, so the next capture falls on the original slot grid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en_i | input | 1 | Advances the interval prescaler when 1 |
| freq_word_i | input | WORD_W | Current loop frequency control word |
| locked_i | input | 1 | 1 when the loop is in normal mode and locked |
| holdover_req_i | input | 1 | 1 while holdover is requested |
| held_word_o | output | WORD_W | Older snapshot, applied during holdover |
| held_valid_o | output | 1 | 1 once two snapshots have been taken |

## Verification
A capture takes place on the clock edge of an enabled sample slot. `held_word_o` and `held_valid_o` are decoded directly from registers, so both show the new state one cycle after the capturing edge, with no further pipeline stage. The bench model updates on each rising edge from the inputs held stable since the previous falling edge, and compares both outputs on the falling edge. Every result is therefore checked in exactly the cycle it is due. Holdover and unlock windows are placed across slot boundaries, so skipped slots and the unshifted schedule after them are exercised.

// File: rtl/hws_pkg.sv
package hws_pkg;
  localparam int unsigned FILL_FULL = 2;

  // saturating count of completed captures
  function automatic logic [1:0] fill_next(input logic [1:0] cnt);
    return (cnt >= 2'(FILL_FULL)) ? cnt : cnt + 2'd1;
  endfunction

  function automatic logic fill_done(input logic [1:0] cnt);
    return cnt >= 2'(FILL_FULL);
  endfunction

  // slot at end of interval: counter at last value and enabled
  function automatic logic slot_hit(input int unsigned cnt, input int unsigned period,
                                    input logic en);
    return en && (cnt == period - 1);
  endfunction
endpackage

// File: rtl/hws_prescaler.sv
module hws_prescaler #(
  parameter int unsigned PERIOD = 1300000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en_i,
  output logic slot_o
);
  import hws_pkg::*;
  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  generate
    if (PERIOD <= 1) begin : g_direct
      assign slot_o = tick_en_i;
    end else begin : g_count
      logic [CW-1:0] cnt_q;
      assign slot_o = slot_hit(int'(cnt_q), PERIOD, tick_en_i);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (slot_o)     cnt_q <= '0;
        else if (tick_en_i)  cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/hws_bank.sv
module hws_bank #(
  parameter int unsigned WORD_W       = 32,
  parameter logic [WORD_W-1:0] NOMINAL_WORD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] older_o,
  output logic              valid_o
);
  import hws_pkg::*;
  localparam int unsigned DEPTH = 2;

  logic [WORD_W-1:0] snap_q [DEPTH];
  logic              wr_ptr_q;
  logic [1:0]        fill_q;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_snap
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 snap_q[i] <= NOMINAL_WORD;
        else if (capture_i && (wr_ptr_q == 1'(i)))  snap_q[i] <= word_i;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= 1'b0;
      fill_q   <= 2'd0;
    end else if (capture_i) begin
      wr_ptr_q <= ~wr_ptr_q;
      fill_q   <= fill_next(fill_q);
    end
  end

  // slot about to be overwritten is the older one
  assign older_o = snap_q[wr_ptr_q];
  assign valid_o = fill_done(fill_q);
endmodule

// File: rtl/holdover_word_store.sv
module holdover_word_store #(
  parameter int unsigned WORD_W       = 32,
  parameter int unsigned CLK_HZ       = 50000000,
  parameter int unsigned INTERVAL_US  = 26000,
  parameter logic [WORD_W-1:0] NOMINAL_WORD = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en_i,
  input  logic [WORD_W-1:0] freq_word_i,
  input  logic              locked_i,
  input  logic              holdover_req_i,
  output logic [WORD_W-1:0] held_word_o,
  output logic              held_valid_o
);
  localparam int unsigned PERIOD = (CLK_HZ / 1000000) * INTERVAL_US;

  logic sample_tick;
  logic capture_evt;

  hws_prescaler #(.PERIOD(PERIOD)) u_presc (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en_i (tick_en_i),
    .slot_o    (sample_tick)
  );

  assign capture_evt = sample_tick && locked_i && !holdover_req_i;

  hws_bank #(.WORD_W(WORD_W), .NOMINAL_WORD(NOMINAL_WORD)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_i (capture_evt),
    .word_i    (freq_word_i),
    .older_o   (held_word_o),
    .valid_o   (held_valid_o)
  );
endmodule

// File: rtl/holdover_word_store_chk.sv
module holdover_word_store_chk #(
  parameter int unsigned WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en_i,
  input logic              locked_i,
  input logic              holdover_req_i,
  input logic [WORD_W-1:0] held_word_o,
  input logic              held_valid_o,
  input logic              capture_evt
);
  // R2
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en_i |=> $stable(held_word_o) && $stable(held_valid_o));
  // R4
  unlocked_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !locked_i |=> $stable(held_word_o) && $stable(held_valid_o));
  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    holdover_req_i |=> $stable(held_word_o));
  // R6
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held_valid_o |=> held_valid_o);
  // R6
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held_valid_o) |-> $past(capture_evt));
  // R7
  word_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(held_word_o) |-> $past(capture_evt));
endmodule

bind holdover_word_store holdover_word_store_chk #(.WORD_W(WORD_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .tick_en_i      (tick_en_i),
  .locked_i       (locked_i),
  .holdover_req_i (holdover_req_i),
  .held_word_o    (held_word_o),
  .held_valid_o   (held_valid_o),
  .capture_evt    (capture_evt)
);

// File: tb/holdover_word_store_tb.sv
module holdover_word_store_tb;
  localparam int unsigned W      = 32;
  localparam int unsigned CLKHZ  = 50000000;
  localparam int unsigned IVL_US = 1;
  localparam int unsigned PER    = (CLKHZ / 1000000) * IVL_US;  // 50
  localparam logic [W-1:0] NOM   = 32'h8000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0, locked = 1'b0, hold = 1'b0;
  logic [W-1:0] word = '0;
  logic [W-1:0] held;
  logic valid;

  int compared = 0, mismatched = 0;
  string tag = "R1";

  always #10 clk = ~clk;  // 50 MHz

  holdover_word_store #(.WORD_W(W), .CLK_HZ(CLKHZ), .INTERVAL_US(IVL_US),
                        .NOMINAL_WORD(NOM)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en_i(tick_en), .freq_word_i(word),
    .locked_i(locked), .holdover_req_i(hold),
    .held_word_o(held), .held_valid_o(valid));

  // behavioural reference: enabled-cycle count and list of captured words
  int unsigned en_cycles = 0;
  logic [W-1:0] caps [$];

  function automatic logic [W-1:0] exp_word();
    return (caps.size() >= 2) ? caps[caps.size()-2] : NOM;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      en_cycles = 0;
      caps.delete();
    end else if (tick_en) begin
      en_cycles++;
      if (en_cycles % PER == 0 && locked && !hold) caps.push_back(word);
    end
  end

  task automatic check(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // compare on every falling edge (R3 word, R6 flag)
  always @(negedge clk) begin
    if (rst_n) begin
      check({tag, "/R3 word"}, held, exp_word());
      check({tag, "/R6 valid"}, W'(valid), W'(caps.size() >= 2));
    end
  end

  int unsigned cyc = 0;
  always @(negedge clk) begin
    cyc++;
    word <= 32'h1234_0000 + cyc * 7;
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    run(3);
    // R1: outputs at nominal while in reset
    check("R1 reset word", held, NOM);
    check("R1 reset valid", W'(valid), '0);
    rst_n = 1'b1;
    run(1);
    check("R1 post-reset word", held, NOM);
    check("R1 post-reset valid", W'(valid), '0);
  endtask

  logic [W-1:0] frozen;

  initial begin
    do_reset();
    tag = "R2";
    locked = 1'b1;
    // R2: disabled prescaler never yields a slot
    run(3 * PER);
    check("R2 no slot while tick_en low", W'(valid), '0);
    tick_en = 1'b1;
    // R6: one capture only -> still invalid, R3 still nominal
    run(PER + 2);
    tag = "R6";
    check("R6 invalid after one capture", W'(valid), '0);
    check("R3 nominal after one capture", held, NOM);
    run(PER);
    check("R6 valid after two captures", W'(valid), 1);
    tag = "R3";
    run(4 * PER);
    // R2: tick_en toggled every other cycle stretches the interval
    tag = "R2";
    for (int i = 0; i < 6 * PER; i++) begin
      tick_en = i[0];
      run(1);
    end
    tick_en = 1'b1;
    // R5: holdover across two slot boundaries
    tag = "R5";
    run(PER / 3);
    hold = 1'b1;
    frozen = held;
    run(2 * PER + 5);
    check("R5 held word frozen in holdover", held, frozen);
    hold = 1'b0;
    // R8: next capture follows original grid (per-cycle compare)
    tag = "R8";
    run(3 * PER);
    // R4: unlocked slots capture nothing
    tag = "R4";
    locked = 1'b0;
    frozen = held;
    run(2 * PER + 3);
    check("R4 held word unchanged while unlocked", held, frozen);
    locked = 1'b1;
    tag = "R7";
    run(3 * PER);
    // reset mid-run returns to nominal
    do_reset();
    tag = "R3";
    run(3 * PER);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule